// File: doc/BRIEF.md
# Four-Lane Packet Framer and Byte Striper

This block sits on the transmit side of a serial link, between the transaction layer and the lane encoders. It takes one packet at a time as a byte stream with start and end markers. A transaction packet (a 12- or 16-octet header, 0 to 4096 data octets and an optional 4-octet end-to-end CRC, all passed through untouched) gets a 2-octet sequence number in front and a 4-octet link CRC behind. A link-control packet (a 4-octet body) gets a 2-octet CRC behind. Either kind is then enclosed in a start symbol and an end symbol.

The framed bytes are dealt across four lanes, one byte per lane in turn. Each output beat carries one byte per lane plus a per-lane flag that marks framing symbols. A frame whose length is not a multiple of four is closed with flagged pad bytes, so every frame starts on lane 0. The producer is throttled with a ready signal while the block inserts its own bytes.

Top module: `tlp_lane_framer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `out_valid` and `in_ready` are low. The first transaction packet after reset uses sequence number 0.
- R2: A transaction packet is framed as: start symbol 0xFB, sequence high octet, sequence low octet, every input byte in order, the 4 link-CRC octets with the most significant octet first, then end symbol 0xFD.
- R3: The sequence number is 12 bits. The high octet is `{4'h0, seq[11:8]}` and the low octet is `seq[7:0]`. It advances by one after each transaction packet and wraps from 4095 to 0.
- R4: The link CRC is CRC-32 with polynomial 0x04C11DB7 and initial value 0xFFFFFFFF. It is fed most significant bit first over the two sequence octets and then all input bytes, and the final value is inverted before it is sent.
- R5: A packet presented with `in_is_dllp` high on its first byte is framed as: start symbol 0x5C, its body bytes, 2 CRC octets with the most significant first, then 0xFD. It does not use or advance the sequence number.
- R6: The link-control CRC is 16 bits with polynomial 0x100B and initial value 0xFFFF. It is fed most significant bit first over the body bytes, and the final value is inverted before it is sent.
- R7: Framed byte k of a frame goes to lane k mod 4 of beat k/4. Lane i occupies `out_data[8*i+7:8*i]`. `out_valid` is high for one cycle per complete beat, so two beats are never on adjacent cycles. The start symbol is always on lane 0.
- R8: `out_ctrl[i]` is set exactly for start symbols, end symbols and pad bytes, and is clear for sequence, payload and CRC bytes.
- R9: When a frame length is not a multiple of four, the lanes after the end symbol in the last beat carry 0x00 with `out_ctrl` set. Lane 0 never carries a pad.
- R10: `in_ready` is low while the block emits its own bytes. From idle, the first byte of a transaction packet is accepted after 3 cycles of `in_ready` low, and that of a link-control packet after 1 cycle. Cycles with `in_valid` low in the middle of a packet only pause the frame.
- R11: While idle, a byte presented without `in_sop` is accepted and discarded. It produces no output and leaves the sequence number unchanged.
- R12: After the byte marked `in_eop` is accepted, no further byte is accepted until the frame's trailing octets have been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte taken on this edge when `in_valid` is high |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| in_is_dllp | input | 1 | With `in_sop`: packet is link-control rather than transaction |
| out_valid | output | 1 | Beat present on the lanes |
| out_data | output | 32 | Four lane bytes, lane 0 in the low octet |
| out_ctrl | output | 4 | Per-lane framing-symbol flag |

## Verification
A behavioural model in the bench builds each frame's expected byte list, including sequence, CRC and pads, and compares every beat. Packet lengths from 12 to 272 bytes are chosen so that the frame length modulo four takes every value, which separates correct padding from early or late pad insertion. Link-control packets placed between transaction packets show whether the sequence number wrongly advances or the wrong CRC width is used. Input gaps, back-to-back packets, a stray unmarked byte and a run of more than 4096 packets check pausing, ready timing and the 12-bit sequence wrap.

// File: rtl/tlp_lane_framer.sv
module tlp_lane_framer #(
  parameter int LANES = 4,
  parameter int SEQ_W = 12,
  parameter logic [31:0] LCRC_POLY = 32'h04C11DB7,
  parameter logic [15:0] DCRC_POLY = 16'h100B
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [7:0]           in_data,
  input  logic                 in_sop,
  input  logic                 in_eop,
  input  logic                 in_is_dllp,
  output logic                 out_valid,
  output logic [8*LANES-1:0]   out_data,
  output logic [LANES-1:0]     out_ctrl
);
  localparam int LW = $clog2(LANES);
  localparam logic [LW-1:0] LAST = LW'(LANES - 1);
  localparam logic [7:0] K_STP = 8'hFB;
  localparam logic [7:0] K_SDP = 8'h5C;
  localparam logic [7:0] K_END = 8'hFD;
  localparam logic [7:0] K_PAD = 8'h00;

  typedef enum logic [2:0] {S_IDLE, S_SEQH, S_SEQL, S_PAY, S_CRC, S_END, S_PAD} st_t;

  st_t st, st_nx;
  logic                   dllp_q;
  logic [SEQ_W-1:0]       seq_q;
  logic [31:0]            lcrc_q;
  logic [15:0]            dcrc_q;
  logic [1:0]             cnt_q;
  logic [LW-1:0]          lane_q;
  logic [8*(LANES-1)-1:0] acc_b;
  logic [LANES-2:0]       acc_c;

  logic       fb_vld, fb_ctl, fb_crc;
  logic [7:0] fb_byte;

  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic        fbk;
    r = c;
    for (int b = 7; b >= 0; b--) begin
      fbk = r[31] ^ d[b];
      r = {r[30:0], 1'b0} ^ (fbk ? LCRC_POLY : 32'h0);
    end
    return r;
  endfunction

  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic        fbk;
    r = c;
    for (int b = 7; b >= 0; b--) begin
      fbk = r[15] ^ d[b];
      r = {r[14:0], 1'b0} ^ (fbk ? DCRC_POLY : 16'h0);
    end
    return r;
  endfunction

  wire [15:0] seq16    = 16'(seq_q);
  wire [31:0] lsh      = (~lcrc_q) << {cnt_q, 3'b000};
  wire [15:0] dsh      = (~dcrc_q) << {cnt_q, 3'b000};
  wire        crc_last = dllp_q ? (cnt_q == 2'd1) : (cnt_q == 2'd3);
  wire        beat_end = (lane_q == LAST);

  always_comb begin
    st_nx    = st;
    fb_vld   = 1'b0;
    fb_ctl   = 1'b0;
    fb_crc   = 1'b0;
    fb_byte  = K_PAD;
    in_ready = 1'b0;
    case (st)
      S_IDLE: begin
        in_ready = in_valid & ~in_sop;
        if (in_valid && in_sop) begin
          fb_vld  = 1'b1;
          fb_ctl  = 1'b1;
          fb_byte = in_is_dllp ? K_SDP : K_STP;
          st_nx   = in_is_dllp ? S_PAY : S_SEQH;
        end
      end
      S_SEQH: begin
        fb_vld  = 1'b1;
        fb_crc  = 1'b1;
        fb_byte = seq16[15:8];
        st_nx   = S_SEQL;
      end
      S_SEQL: begin
        fb_vld  = 1'b1;
        fb_crc  = 1'b1;
        fb_byte = seq16[7:0];
        st_nx   = S_PAY;
      end
      S_PAY: begin
        in_ready = 1'b1;
        fb_vld   = in_valid;
        fb_crc   = in_valid;
        fb_byte  = in_data;
        if (in_valid && in_eop) st_nx = S_CRC;
      end
      S_CRC: begin
        fb_vld  = 1'b1;
        fb_byte = dllp_q ? dsh[15:8] : lsh[31:24];
        if (crc_last) st_nx = S_END;
      end
      S_END: begin
        fb_vld  = 1'b1;
        fb_ctl  = 1'b1;
        fb_byte = K_END;
        st_nx   = beat_end ? S_IDLE : S_PAD;
      end
      S_PAD: begin
        fb_vld  = 1'b1;
        fb_ctl  = 1'b1;
        fb_byte = K_PAD;
        if (beat_end) st_nx = S_IDLE;
      end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      dllp_q <= 1'b0;
      seq_q  <= '0;
      lcrc_q <= '1;
      dcrc_q <= '1;
      cnt_q  <= '0;
    end else begin
      st    <= st_nx;
      cnt_q <= (st == S_CRC) ? cnt_q + 2'd1 : 2'd0;
      if (st == S_IDLE && in_valid && in_sop) begin
        dllp_q <= in_is_dllp;
        lcrc_q <= '1;
        dcrc_q <= '1;
      end else if (fb_crc) begin
        if (dllp_q) dcrc_q <= crc16_step(dcrc_q, fb_byte);
        else        lcrc_q <= crc32_step(lcrc_q, fb_byte);
      end
      if (st == S_END && !dllp_q) seq_q <= seq_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q    <= '0;
      acc_b     <= '0;
      acc_c     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ctrl  <= '0;
    end else begin
      out_valid <= fb_vld && beat_end;
      if (fb_vld) begin
        lane_q <= beat_end ? '0 : lane_q + 1'b1;
        if (beat_end) begin
          out_data <= {fb_byte, acc_b};
          out_ctrl <= {fb_ctl, acc_c};
        end
        if (LANES > 2) begin
          acc_b <= {fb_byte, acc_b[8*(LANES-1)-1:8]};
          acc_c <= {fb_ctl, acc_c[LANES-2:1]};
        end else begin
          acc_b <= fb_byte;
          acc_c <= fb_ctl;
        end
      end
    end
  end
endmodule

module tlp_lane_framer_chk #(
  parameter int LANES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               in_eop,
  input logic [2:0]         st,
  input logic               out_valid,
  input logic [8*LANES-1:0] out_data,
  input logic [LANES-1:0]   out_ctrl
);
  localparam logic [2:0] PAY_STATE = 3'd3;

  AST_BEAT_GAP: assert property (@(posedge clk) disable iff (!rst_n) out_valid |=> !out_valid); // R7
  AST_EOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (st == PAY_STATE && in_valid && in_eop) |=> !in_ready); // R12
  AST_PAD_NOT_LANE0: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_ctrl[0]) |-> out_data[7:0] != 8'h00); // R9

  for (genvar i = 0; i < LANES; i++) begin : g_all
    AST_CTRL_CODES: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ctrl[i]) |-> (out_data[8*i+:8] == 8'hFB || out_data[8*i+:8] == 8'h5C ||
                                      out_data[8*i+:8] == 8'hFD || out_data[8*i+:8] == 8'h00)); // R8
  end

  for (genvar i = 1; i < LANES; i++) begin : g_hi
    AST_START_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ctrl[i]) |-> (out_data[8*i+:8] != 8'hFB && out_data[8*i+:8] != 8'h5C)); // R7
    AST_PAD_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ctrl[i] && out_data[8*i+:8] == 8'h00) |-> out_ctrl[i-1]); // R9
  end
endmodule

bind tlp_lane_framer tlp_lane_framer_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_eop(in_eop),
  .st(st), .out_valid(out_valid), .out_data(out_data), .out_ctrl(out_ctrl)
);

// File: tb/tlp_lane_framer_test.sv
module tlp_lane_framer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_is_dllp = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready, out_valid;
  logic [31:0] out_data;
  logic [3:0]  out_ctrl;

  int vectors = 0, fails = 0, beats = 0, seq_m = 0;
  string cur_req = "R1";
  logic [7:0] body_q[$];
  logic [7:0] crc_in[$];
  logic [7:0] exp_b[$];
  bit         exp_c[$];

  tlp_lane_framer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_is_dllp(in_is_dllp),
    .out_valid(out_valid), .out_data(out_data), .out_ctrl(out_ctrl)
  );

  function automatic logic [31:0] ref_crc(input bit dllp);
    logic [31:0] mask = dllp ? 32'h0000FFFF : 32'hFFFFFFFF;
    logic [31:0] top  = dllp ? 32'h00008000 : 32'h80000000;
    logic [31:0] poly = dllp ? 32'h0000100B : 32'h04C11DB7;
    logic [31:0] c    = mask;
    bit hi;
    foreach (crc_in[i]) begin
      for (int b = 7; b >= 0; b--) begin
        hi = ((c & top) != 0) ^ crc_in[i][b];
        c = (c << 1) & mask;
        if (hi) c = c ^ poly;
      end
    end
    return ~c & mask;
  endfunction

  task automatic model_frame(input bit dllp);
    int n;
    logic [31:0] cr;
    n = 0;
    crc_in.delete();
    exp_b.push_back(dllp ? 8'h5C : 8'hFB); exp_c.push_back(1'b1); n++;
    if (!dllp) begin
      crc_in.push_back({4'h0, 4'(seq_m >> 8)});
      crc_in.push_back(8'(seq_m));
    end
    foreach (body_q[i]) crc_in.push_back(body_q[i]);
    foreach (crc_in[i]) begin exp_b.push_back(crc_in[i]); exp_c.push_back(1'b0); n++; end
    cr = ref_crc(dllp);
    for (int k = (dllp ? 1 : 3); k >= 0; k--) begin
      exp_b.push_back(8'(cr >> (8 * k))); exp_c.push_back(1'b0); n++;
    end
    exp_b.push_back(8'hFD); exp_c.push_back(1'b1); n++;
    while (n % 4 != 0) begin exp_b.push_back(8'h00); exp_c.push_back(1'b1); n++; end
    if (!dllp) seq_m = (seq_m + 1) % 4096;
  endtask

  task automatic send_pkt(input bit dllp, input int len, input int gap, output int stall0);
    body_q.delete();
    for (int i = 0; i < len; i++) body_q.push_back(8'($urandom_range(0, 255)));
    model_frame(dllp);
    stall0 = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = body_q[i]; in_sop = (i == 0); in_eop = (i == len - 1);
      in_is_dllp = dllp;
      #1;
      while (!in_ready) begin
        if (i == 0) stall0++;
        @(negedge clk); #1;
      end
      if (gap > 0 && i < len - 1) begin
        @(negedge clk); in_valid = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_is_dllp = 1'b0;
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      logic [31:0] ed;
      logic [3:0]  ec;
      beats++;
      vectors++;
      if (exp_b.size() < 4) begin
        fails++;
        $display("FAIL %s R7 unexpected beat actual=%h/%b expected=none", cur_req, out_data, out_ctrl);
      end else begin
        for (int k = 0; k < 4; k++) begin
          ed[8*k+:8] = exp_b.pop_front();
          ec[k] = exp_c.pop_front();
        end
        if (ed !== out_data || ec !== out_ctrl) begin
          fails++;
          $display("FAIL %s beat actual=%h/%b expected=%h/%b", cur_req, out_data, out_ctrl, ed, ec);
        end
      end
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int st0, nb, wraps;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b0, "R1", "in reset valid/ready", int'({out_valid, in_ready}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b0, "R1", "after reset valid/ready", int'({out_valid, in_ready}), 0);

    cur_req = "R2"; send_pkt(1'b0, 12, 0, st0);
    check(st0 == 3, "R10", "TLP first-byte stall", st0, 3);
    cur_req = "R9"; send_pkt(1'b0, 13, 0, st0);
    send_pkt(1'b0, 14, 0, st0);
    send_pkt(1'b0, 15, 0, st0);
    cur_req = "R4"; send_pkt(1'b0, 24, 0, st0);
    send_pkt(1'b0, 28, 0, st0);
    repeat (6) @(negedge clk);
    cur_req = "R5"; send_pkt(1'b1, 4, 0, st0);
    check(st0 == 1, "R10", "DLLP first-byte stall", st0, 1);
    cur_req = "R6"; send_pkt(1'b1, 4, 2, st0);
    cur_req = "R3"; send_pkt(1'b0, 16, 0, st0);
    cur_req = "R10"; send_pkt(1'b0, 20, 3, st0);
    send_pkt(1'b0, 17, 1, st0);
    cur_req = "R12"; send_pkt(1'b0, 12, 0, st0); send_pkt(1'b1, 4, 0, st0); send_pkt(1'b0, 18, 0, st0);
    cur_req = "R7"; send_pkt(1'b0, 272, 0, st0);
    repeat (10) @(negedge clk);

    cur_req = "R11";
    @(negedge clk); in_valid = 1'b1; in_sop = 1'b0; in_data = 8'hFB; #1;
    check(in_ready == 1'b1, "R11", "stray byte accepted", int'(in_ready), 1);
    @(negedge clk); in_valid = 1'b0;
    nb = beats;
    repeat (10) @(negedge clk);
    check(beats == nb, "R11", "stray byte output beats", beats - nb, 0);
    send_pkt(1'b0, 12, 0, st0);

    cur_req = "R3";
    wraps = 4098 - seq_m;
    for (int p = 0; p < wraps; p++) send_pkt(1'b0, 12, 0, st0);
    check(seq_m == 2, "R3", "model sequence after wrap", seq_m, 2);
    send_pkt(1'b1, 4, 0, st0);
    send_pkt(1'b0, 13, 0, st0);

    repeat (30) @(negedge clk);
    check(exp_b.size() == 0, "R7", "bytes left undelivered", exp_b.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule